// File: doc/BRIEF.md
# Monochrome STN Panel Timing Generator

This block drives a 320×240 monochrome STN dot-matrix panel that takes pixel data four bits at a time. It runs from one 2 MHz clock. From that clock it derives five things: the nibble shift clock, a one-clock row latch strobe, a frame-start marker, an alternating drive polarity line and a display blank control. It also produces a 15-bit read address, so that the frame buffer can present the correct nibble for each shift clock.

Each row lasts 120 clocks. The first 80 clocks form the data window, and in each of them one shift-clock pulse moves one nibble into the column driver. One clock of row latch follows. The last 39 clocks are blank. A frame is 240 rows. The frame marker covers the first row of each frame. The polarity line reverses at every frame boundary, so that the liquid crystal never sees a DC bias. Three small state machines handle the work: one for the row, one for the frame and one for the polarity. A gated clock and an address counter complete the block.

Top module: `lcd_stn_timing`

## Requirements
- R1: Every row is 120 clocks: 80 data-window clocks, then exactly one clock with `line_latch` high, then 39 clocks with both the data window and `line_latch` low. The data window and the latch are never active together.
- R2: `shift_clk` is the inverted input clock, gated so that it is high only during the second half of each data-window clock and low at all other times. Each row therefore carries exactly 80 `shift_clk` pulses.
- R3: `frame_mark` is high for all 120 clocks of row 0 of each 240-row frame (28,800 clocks) and low for the other 239 rows.
- R4: `polarity` is 0 throughout the first frame after reset. It inverts at each frame boundary, in the same clock in which `frame_mark` rises.
- R5: `rd_addr` is 0 at the start of every frame. During data-window clock c of row r it equals r·80+c. It holds its value outside the data window, and after 19,199 it wraps to 0.
- R6: `disp_blank` is 1 (display blanked) from reset through the whole first frame. It falls to 0 at the first frame boundary and stays at 0 until the next reset.
- R7: While `rst_n` is low (asserted asynchronously), the outputs take their reset values: `shift_clk`=0, `line_latch`=0, `frame_mark`=0, `polarity`=0, `disp_blank`=1 and `rd_addr`=0. Release is synchronised. Row 0 of frame 0 begins (`frame_mark` high) on the second rising clock edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 2 MHz timing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| shift_clk | output | 1 | Gated nibble shift clock to the column driver |
| line_latch | output | 1 | One-clock row latch strobe |
| frame_mark | output | 1 | High for the first row of each frame |
| polarity | output | 1 | Drive polarity, inverted every frame |
| disp_blank | output | 1 | 1 while the display is to be blanked |
| rd_addr | output | 15 | Frame buffer nibble read address |

## Verification
The bench checks every output in every clock against a model indexed by the clock count. It watches closely for a row that carries 79 or 81 shift pulses, or a latch strobe that is off by one position, either of which would skew every row on the panel. It runs past two frame boundaries. There it catches an address that fails to wrap from 19,199 (it would overrun into unused memory), a polarity line that flips at the wrong point or not at all, and a blank line that releases one frame early or late. Asynchronous resets asserted at random points inside a row must restart cleanly at row 0. A design that resumes mid-row would misalign the marker and the addresses.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic [1:0] {
    L_DATA  = 2'd0,
    L_LATCH = 2'd1,
    L_IDLE  = 2'd2
  } line_state_e;

  typedef enum logic {
    F_FIRST = 1'b0,
    F_REST  = 1'b1
  } frame_state_e;
endpackage

// File: rtl/lcd_line_fsm.sv
module lcd_line_fsm
  import lcd_pkg::*;
#(
  parameter int ACTIVE_CLKS = 80,
  parameter int BLANK_CLKS  = 39
) (
  input  logic clk,
  input  logic rst_n,
  output logic den_o,
  output logic lp_o,
  output logic eol_o
);
  localparam int MAXC = (ACTIVE_CLKS > BLANK_CLKS) ? ACTIVE_CLKS : BLANK_CLKS;
  localparam int CW   = $clog2(MAXC + 1);

  line_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CW'(1);
    unique case (state_q)
      L_DATA: if (cnt_q == CW'(ACTIVE_CLKS - 1)) begin
        state_d = L_LATCH;
        cnt_d   = '0;
      end
      L_LATCH: begin
        state_d = L_IDLE;
        cnt_d   = '0;
      end
      L_IDLE: if (cnt_q == CW'(BLANK_CLKS - 1)) begin
        state_d = L_DATA;
        cnt_d   = '0;
      end
      default: begin
        state_d = L_DATA;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= L_DATA;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign den_o = (state_q == L_DATA);
  assign lp_o  = (state_q == L_LATCH);
  assign eol_o = (state_q == L_IDLE) && (cnt_q == CW'(BLANK_CLKS - 1));

  // R1: latch strobe lasts one clock and never overlaps the data window
  a_r1_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
    lp_o |=> !lp_o);
  a_r1_latch_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    lp_o |-> $past(den_o));
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(den_o && lp_o));
endmodule

// File: rtl/lcd_frame_fsm.sv
module lcd_frame_fsm
  import lcd_pkg::*;
#(
  parameter int LINES = 240
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eol_i,
  output logic flm_o,
  output logic wrap_o
);
  localparam int LW = $clog2(LINES);

  frame_state_e  state_q, state_d;
  logic [LW-1:0] line_q, line_d;

  assign wrap_o = eol_i && (line_q == LW'(LINES - 1));

  always_comb begin
    state_d = state_q;
    line_d  = line_q;
    if (eol_i) begin
      unique case (state_q)
        F_FIRST: begin
          state_d = F_REST;
          line_d  = LW'(1);
        end
        F_REST: begin
          if (line_q == LW'(LINES - 1)) begin
            state_d = F_FIRST;
            line_d  = '0;
          end else begin
            line_d = line_q + LW'(1);
          end
        end
        default: begin
          state_d = F_FIRST;
          line_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= F_FIRST;
      line_q  <= '0;
    end else begin
      state_q <= state_d;
      line_q  <= line_d;
    end
  end

  assign flm_o = (state_q == F_FIRST);

  // R3: the marker starts and ends only at a row boundary
  a_r3_mark_enters_at_row: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flm_o) |-> $past(eol_i));
  a_r3_mark_leaves_at_row: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flm_o) |-> $past(eol_i));
endmodule

// File: rtl/lcd_polarity.sv
module lcd_polarity (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  output logic m_o,
  output logic blank_o
);
  logic m_q, m_d, blank_q, blank_d;

  always_comb begin
    m_d     = wrap_i ? ~m_q : m_q;
    blank_d = wrap_i ? 1'b0 : blank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q     <= 1'b0;
      blank_q <= 1'b1;
    end else begin
      m_q     <= m_d;
      blank_q <= blank_d;
    end
  end

  assign m_o     = m_q;
  assign blank_o = blank_q;

  // R4: polarity changes only after a frame wrap
  a_r4_flip_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(m_q) |-> $past(wrap_i));
  // R6: once released, blanking stays off
  a_r6_blank_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_q |=> !blank_q);
endmodule

// File: rtl/lcd_addr_gen.sv
module lcd_addr_gen #(
  parameter int ADDR_W = 15,
  parameter int LAST   = 19199
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              clr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (clr_i)
      addr_d = '0;
    else if (en_i)
      addr_d = (addr_q == ADDR_W'(LAST)) ? '0 : addr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  // R5: address stays inside the frame and moves only when enabled
  a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= ADDR_W'(LAST));
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en_i) && !$past(clr_i)) |-> $stable(addr_q));
endmodule

// File: rtl/lcd_stn_timing.sv
module lcd_stn_timing #(
  parameter int ACTIVE_CLKS = 80,
  parameter int BLANK_CLKS  = 39,
  parameter int LINES       = 240,
  parameter int ADDR_W      = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              shift_clk,
  output logic              line_latch,
  output logic              frame_mark,
  output logic              polarity,
  output logic              disp_blank,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int NIBBLES = LINES * ACTIVE_CLKS;

  logic sync1_q, run_q;
  logic den, lp, eol, flm, wrap, den_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      run_q   <= sync1_q;
    end
  end

  lcd_line_fsm #(.ACTIVE_CLKS(ACTIVE_CLKS), .BLANK_CLKS(BLANK_CLKS)) u_line (
    .clk(clk), .rst_n(run_q), .den_o(den), .lp_o(lp), .eol_o(eol)
  );

  lcd_frame_fsm #(.LINES(LINES)) u_frame (
    .clk(clk), .rst_n(run_q), .eol_i(eol), .flm_o(flm), .wrap_o(wrap)
  );

  lcd_polarity u_pol (
    .clk(clk), .rst_n(run_q), .wrap_i(wrap), .m_o(polarity), .blank_o(disp_blank)
  );

  lcd_addr_gen #(.ADDR_W(ADDR_W), .LAST(NIBBLES - 1)) u_addr (
    .clk(clk), .rst_n(run_q), .en_i(den_run), .clr_i(wrap), .addr_o(rd_addr)
  );

  // both terms are flop outputs that change at the rising edge, while ~clk is low
  assign den_run    = den & run_q;
  assign shift_clk  = ~clk & den_run;
  assign line_latch = lp & run_q;
  assign frame_mark = flm & run_q;

  // R4: polarity flips exactly when a new frame marker starts
  a_r4_flip_with_mark: assert property (@(posedge clk) disable iff (!run_q)
    !$stable(polarity) |-> $rose(frame_mark));
endmodule

// File: tb/lcd_stn_timing_test.sv
`timescale 1ns/1ps
module lcd_stn_timing_test;
  localparam int ROW   = 120;
  localparam int DATA  = 80;
  localparam int LINES = 240;
  localparam int FRAME = ROW * LINES;
  localparam int NIB   = DATA * LINES;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        shift_clk, line_latch, frame_mark, polarity, disp_blank;
  logic [14:0] rd_addr;

  int checks = 0, errors = 0, t = 0, cp_cnt = 0, cp_base = 0;
  bit base_ok = 0, done = 0;

  always #5 clk = ~clk;
  always @(posedge shift_clk) cp_cnt++;

  lcd_stn_timing uut (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .line_latch(line_latch),
    .frame_mark(frame_mark), .polarity(polarity), .disp_blank(disp_blank),
    .rd_addr(rd_addr)
  );

  function automatic int f_col(int tt);   return tt % ROW; endfunction
  function automatic int f_line(int tt);  return (tt / ROW) % LINES; endfunction
  function automatic int f_frame(int tt); return tt / FRAME; endfunction
  function automatic int f_addr(int tt);
    int c = f_col(tt);
    return (f_line(tt) * DATA + ((c < DATA) ? c : DATA)) % NIB;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at t=%0d: got %0d expected %0d", req, t, act, expv);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk_reset_state(input string tag);
    chk(shift_clk == 1'b0, {"R7 shift_clk ", tag}, shift_clk, 0);
    chk(line_latch == 1'b0, {"R7 line_latch ", tag}, line_latch, 0);
    chk(frame_mark == 1'b0, {"R7 frame_mark ", tag}, frame_mark, 0);
    chk(polarity == 1'b0, {"R7 polarity ", tag}, polarity, 0);
    chk(disp_blank == 1'b1, {"R7 disp_blank ", tag}, disp_blank, 1);
    chk(rd_addr == 15'd0, {"R7 rd_addr ", tag}, rd_addr, 0);
  endtask

  // after release: row 0 must begin on the second rising edge
  task automatic align;
    int seen = 0;
    for (int k = 0; k < 4 && seen == 0; k++) begin
      @(posedge clk); #6;
      if (frame_mark) begin
        seen = 1;
        chk(k == 1, "R7 release latency", k, 1);
      end
    end
    chk(seen == 1, "R7 first frame_mark", seen, 1);
    t = 0;
    base_ok = 0;
  endtask

  task automatic run_seg(input int n);
    for (int i = 0; i < n; i++) begin
      int c = f_col(t);
      // sampled 1 ns after the falling edge: shift_clk equals the data window
      chk(shift_clk == (c < DATA), "R2 shift_clk level", shift_clk, int'(c < DATA));
      chk(line_latch == (c == DATA), "R1 line_latch", line_latch, int'(c == DATA));
      chk(frame_mark == (f_line(t) == 0), "R3 frame_mark", frame_mark, int'(f_line(t) == 0));
      chk(polarity == f_frame(t)[0], "R4 polarity", polarity, f_frame(t) % 2);
      chk(disp_blank == (f_frame(t) == 0), "R6 disp_blank", disp_blank, int'(f_frame(t) == 0));
      chk(int'(rd_addr) == f_addr(t), "R5 rd_addr", int'(rd_addr), f_addr(t));
      if (c == ROW - 1) begin
        if (base_ok) chk(cp_cnt - cp_base == DATA, "R2 pulses per row", cp_cnt - cp_base, DATA);
        cp_base = cp_cnt;
        base_ok = 1;
      end
      @(posedge clk); #6;
      t++;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #6;
    chk_reset_state("power-on");
    @(negedge clk); #2;
    rst_n = 1'b1;
    align();
    // two full frame boundaries: address wrap, polarity flips, blank release
    run_seg(2 * FRAME + 500);
    // random asynchronous resets at arbitrary points of a row
    for (int r = 0; r < 5; r++) begin
      #($urandom_range(1, 9));
      rst_n = 1'b0;
      #1;
      chk_reset_state("async assert");
      repeat ($urandom_range(2, 12)) @(posedge clk);
      #($urandom_range(1, 9));
      chk_reset_state("held");
      rst_n = 1'b1;
      align();
      run_seg($urandom_range(300, 3000));
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(10 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule